// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees a two-wire bus left stuck by a slave that keeps the data line (SDA) low, for example after a reset in the middle of a byte. On a start request it releases both lines. While SDA stays low, it clocks SCL one pulse at a time. Before each pulse it waits for any slave that is stretching the clock to let SCL go high. Once SDA reads high, it drives a start condition and then a stop condition, so every slave on the bus resynchronises.

Both lines are open drain. Each output is an enable: 1 pulls the line low and 0 releases it to the pull-up. The input pins return the level actually seen on the bus. All timing is built from one step of `STEP_US` microseconds, converted to `STEP_CYC = CLK_HZ * STEP_US / 1_000_000` system clocks (at least 1). The run ends in one of two ways. It succeeds with a one-cycle done pulse, or it gives up with a timeout flag. It gives up when `MAX_PULSES` pulses have not released SDA, or when SCL is held low by a slave for `STRETCH_LIMIT` cycles.

Top module: `i2c_bus_recovery`

## Requirements
- R1: After reset, and whenever the sequencer is idle, both pull enables are 0 (lines released), and `done_o` is 0. After reset `timeout_o` is also 0.
- R2: If SDA reads high when a requested run first samples it, no SCL pulse is issued and the run goes straight to the start/stop sequence and ends with done.
- R3: While SDA reads low, the sequencer issues recovery pulses on SCL with SDA released. It stops pulsing as soon as SDA reads high after a pulse, so the pulse count equals the number of SCL rising edges the slave needs.
- R4: Each recovery pulse has three phases: SCL released for `STEP_CYC` cycles, then pulled low for exactly `STEP_CYC` cycles, then released for `STEP_CYC` cycles.
- R5: Before each pulse the sequencer waits while SCL reads low (clock stretching). It never pulls SCL while a slave holds it low in that wait, and it continues once SCL reads high.
- R6: If SDA still reads low after `MAX_PULSES` pulses, the run ends with `timeout_o` set, no done pulse, and both lines released.
- R7: If SCL reads low for `STRETCH_LIMIT` consecutive cycles in a stretch wait, the run ends with `timeout_o` set and both lines released, without pulsing SCL.
- R8: The closing sequence is as follows. SDA is pulled low while SCL is released (start). Then SCL is pulled low and released again, one step each. Then SDA is released while SCL is released (stop). SDA stays pulled for `3 * STEP_CYC` cycles.
- R9: `done_o` is a one-cycle pulse in the same cycle that SDA is released at the end of the stop. `timeout_o` stays at 1 until the next start request is accepted, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a recovery run; accepted only when idle |
| scl_i | input | 1 | Level read back from the SCL line |
| sda_i | input | 1 | Level read back from the SDA line |
| scl_oe_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| done_o | output | 1 | One-cycle pulse when a run ends with SDA free |
| timeout_o | output | 1 | Set when a run gives up; cleared by the next accepted start |

## Verification
The in-RTL assertions watch the pin-level rules on every cycle:
- A start edge is made only with SCL released, and a stop edge only with SCL released.
- Both lines are free when idle and in the done cycle.
- A recovery pulse begins only after SCL has read high.
- Done and timeout never coincide, and done lasts one cycle.

Only the bench scenarios can show the rest:
- The exact pulse count needed for a given slave.
- The step widths.
- Giving up after the pulse cap or an endless clock stretch.
- That a short stretch only delays the run.
- That timeout persists until the next request.

// File: rtl/i2c_rcv_pkg.sv
package i2c_rcv_pkg;

    typedef enum logic [3:0] {
        RCV_IDLE,
        RCV_CHECK,
        RCV_STRETCH,
        RCV_PULSE_PRE,
        RCV_PULSE_LOW,
        RCV_PULSE_POST,
        RCV_END_SDA,
        RCV_END_SCL,
        RCV_END_REL
    } rcv_state_e;

    // Number of system clocks in one timing step, never below one.
    function automatic int unsigned step_cycles(longint unsigned hz, longint unsigned us);
        longint unsigned c;
        c = (hz * us) / 64'd1_000_000;
        return (c < 64'd1) ? 1 : int'(c);
    endfunction

    function automatic logic pulls_scl(rcv_state_e s);
        return (s == RCV_PULSE_LOW) || (s == RCV_END_SCL);
    endfunction

    function automatic logic pulls_sda(rcv_state_e s);
        return (s == RCV_END_SDA) || (s == RCV_END_SCL) || (s == RCV_END_REL);
    endfunction

endpackage

// File: rtl/rcv_step_timer.sv
module rcv_step_timer #(
    parameter int unsigned CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);
    localparam int unsigned W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [W-1:0] RELOAD = W'(CYCLES - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || load)
            cnt_q <= RELOAD;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    // R4
    timer_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/rcv_event_counter.sv
module rcv_event_counter #(
    parameter int unsigned LIMIT = 9
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    localparam int unsigned W = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
    localparam logic [W-1:0] TOP = W'(LIMIT);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (inc && cnt_q != TOP)
            cnt_q <= cnt_q + 1'b1;
    end

    assign at_limit = (cnt_q == TOP);

    // R6
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (at_limit && !clr) |=> at_limit);
endmodule

// File: rtl/i2c_bus_recovery.sv
module i2c_bus_recovery #(
    parameter int unsigned CLK_HZ        = 125_000_000,
    parameter int unsigned STEP_US       = 10,
    parameter int unsigned MAX_PULSES    = 9,
    parameter int unsigned STRETCH_LIMIT = 100_000
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_oe_o,
    output logic sda_oe_o,
    output logic done_o,
    output logic timeout_o
);
    import i2c_rcv_pkg::*;

    localparam int unsigned STEP_CYC = step_cycles(CLK_HZ, STEP_US);
    localparam int unsigned STR_TOP  = (STRETCH_LIMIT > 1) ? STRETCH_LIMIT - 1 : 1;

    rcv_state_e st_q, st_d;
    logic       step_done, pulse_full, stretch_full, give_up;
    logic       scl_q, sda_q, done_q, tmo_q;

    rcv_step_timer #(.CYCLES(STEP_CYC)) i_step (
        .clk(clk), .rst(rst), .load(st_d != st_q), .expired(step_done)
    );

    rcv_event_counter #(.LIMIT(MAX_PULSES)) i_pulses (
        .clk(clk), .rst(rst),
        .clr(st_q == RCV_IDLE),
        .inc(st_q == RCV_PULSE_LOW && step_done),
        .at_limit(pulse_full)
    );

    rcv_event_counter #(.LIMIT(STR_TOP)) i_stretch (
        .clk(clk), .rst(rst),
        .clr(st_q != RCV_STRETCH),
        .inc(st_q == RCV_STRETCH),
        .at_limit(stretch_full)
    );

    assign give_up = (st_q == RCV_CHECK   && !sda_i && pulse_full) ||
                     (st_q == RCV_STRETCH && !scl_i && stretch_full);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RCV_IDLE:       if (start_i) st_d = RCV_CHECK;
            RCV_CHECK:      if (sda_i) st_d = RCV_END_SDA;
                            else if (pulse_full) st_d = RCV_IDLE;
                            else st_d = RCV_STRETCH;
            RCV_STRETCH:    if (scl_i) st_d = RCV_PULSE_PRE;
                            else if (stretch_full) st_d = RCV_IDLE;
            RCV_PULSE_PRE:  if (step_done) st_d = RCV_PULSE_LOW;
            RCV_PULSE_LOW:  if (step_done) st_d = RCV_PULSE_POST;
            RCV_PULSE_POST: if (step_done) st_d = RCV_CHECK;
            RCV_END_SDA:    if (step_done) st_d = RCV_END_SCL;
            RCV_END_SCL:    if (step_done) st_d = RCV_END_REL;
            RCV_END_REL:    if (step_done) st_d = RCV_IDLE;
            default:        st_d = RCV_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= RCV_IDLE;
            scl_q  <= 1'b0;
            sda_q  <= 1'b0;
            done_q <= 1'b0;
            tmo_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            scl_q  <= pulls_scl(st_d);
            sda_q  <= pulls_sda(st_d);
            done_q <= (st_q == RCV_END_REL) && step_done;
            if (st_q == RCV_IDLE && start_i)
                tmo_q <= 1'b0;
            else if (give_up)
                tmo_q <= 1'b1;
        end
    end

    assign scl_oe_o  = scl_q;
    assign sda_oe_o  = sda_q;
    assign done_o    = done_q;
    assign timeout_o = tmo_q;

    // R1
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == RCV_IDLE) |-> (!scl_oe_o && !sda_oe_o));
    // R8
    start_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe_o) |-> (!scl_oe_o && !$past(scl_oe_o)));
    // R8
    stop_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_oe_o) |-> (!scl_oe_o && !$past(scl_oe_o)));
    // R5
    stretch_wait_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(scl_oe_o) && !sda_oe_o) |-> $past(scl_i));
    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    // R9
    done_free_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!scl_oe_o && !sda_oe_o && !timeout_o));
    // R6
    timeout_free_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_o) |-> (!scl_oe_o && !sda_oe_o));
endmodule

// File: tb/test_i2c_bus_recovery.sv
module test_i2c_bus_recovery;
    localparam int unsigned STEP    = 4;
    localparam int unsigned MAXP    = 9;
    localparam int unsigned SLIMIT  = 40;
    localparam int          NVEC    = 5;
    // slave hold: SCL rising edges the slave needs before releasing SDA
    localparam int VHOLD  [NVEC] = '{0, 1, 3, 9, 10};
    localparam int VDONE  [NVEC] = '{1, 1, 1, 1, 0};
    localparam int VPULSE [NVEC] = '{0, 1, 3, 9, 9};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic hold = 1'b0;
    logic force_scl = 1'b0;
    logic scl_oe, sda_oe, done, tmo;
    logic scl_line, sda_line;

    int checks = 0;
    int errors = 0;

    // bench-side results of one run
    int pulses, bad_width, bad_edge, sda_span, elapsed, forced_pulls;
    int saw_done, saw_tmo, done_ok, tmo_after_start;

    always #4 clk = ~clk;

    assign scl_line = !(scl_oe || force_scl);
    assign sda_line = !(sda_oe || hold);

    i2c_bus_recovery #(
        .CLK_HZ(1_000_000), .STEP_US(STEP), .MAX_PULSES(MAXP), .STRETCH_LIMIT(SLIMIT)
    ) i_i2c_bus_recovery (
        .clk(clk), .rst(rst), .start_i(start), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .done_o(done), .timeout_o(tmo)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One recovery run; the slave holds SDA until it has seen k SCL rises,
    // and holds SCL low for fc cycles at the start (fc < 0: forever).
    task automatic run(input int k, input int fc);
        int fl, lowlen, sdalen;
        logic pscl, psda;
        fl = fc; lowlen = 0; sdalen = 0;
        pulses = 0; bad_width = 0; bad_edge = 0; sda_span = 0; elapsed = 0;
        forced_pulls = 0; saw_done = 0; saw_tmo = 0; done_ok = 0; tmo_after_start = -1;
        @(negedge clk);
        hold = (k > 0);
        force_scl = (fl != 0);
        start = 1'b1;
        pscl = scl_oe; psda = sda_oe;
        for (int cyc = 0; cyc < 3000; cyc++) begin
            @(negedge clk);
            start = 1'b0;
            elapsed++;
            if (cyc == 1) tmo_after_start = tmo;
            if (force_scl && scl_oe && !pscl) forced_pulls++;
            if (scl_oe && !sda_oe) lowlen++;
            if (pscl && !scl_oe && !psda) begin
                pulses++;
                if (lowlen != STEP) bad_width++;
                lowlen = 0;
            end
            if (sda_oe) sdalen++;
            if (sda_oe && !psda && (scl_oe || pscl)) bad_edge++;
            if (!sda_oe && psda) begin
                if (scl_oe || pscl) bad_edge++;
                sda_span = sdalen;
            end
            if (done) begin
                saw_done = 1;
                done_ok = (psda && !sda_oe && !scl_oe) ? 1 : 0;
            end
            if (tmo) saw_tmo = 1;
            if (pulses >= k) hold = 1'b0;
            if (fl > 0) fl--;
            force_scl = (fl != 0);
            pscl = scl_oe; psda = sda_oe;
            if (saw_done || saw_tmo) break;
        end
        force_scl = 1'b0;
        hold = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(!scl_oe && !sda_oe, "R1 lines released after reset", {scl_oe, sda_oe}, 0);
        check(!done && !tmo, "R1 flags clear after reset", {done, tmo}, 0);

        for (int v = 0; v < NVEC; v++) begin
            run(VHOLD[v], 0);
            check(saw_done == VDONE[v], "R2/R3/R6 outcome done", saw_done, VDONE[v]);
            check(saw_tmo == 1 - VDONE[v], "R6 outcome timeout", saw_tmo, 1 - VDONE[v]);
            check(pulses == VPULSE[v], "R3 pulse count", pulses, VPULSE[v]);
            check(bad_width == 0, "R4 SCL low width", bad_width, 0);
            check(bad_edge == 0, "R8 start/stop edges with SCL released", bad_edge, 0);
            if (VDONE[v] != 0) begin
                check(sda_span == 3 * STEP, "R8 SDA pulled span", sda_span, 3 * STEP);
                check(done_ok == 1, "R9 done with SDA release", done_ok, 1);
            end else begin
                check(sda_span == 0, "R6 no start/stop on timeout", sda_span, 0);
                check(!scl_oe && !sda_oe, "R6 lines released on timeout", {scl_oe, sda_oe}, 0);
            end
            @(negedge clk);
            check(!done, "R9 done lasts one cycle", done, 0);
            check(!scl_oe && !sda_oe, "R1 idle after run", {scl_oe, sda_oe}, 0);
        end

        // R9: timeout from the last vector persists, then the next start clears it
        repeat (5) @(negedge clk);
        check(tmo == 1'b1, "R9 timeout sticky", tmo, 1);

        // R5: short stretch only delays the pulses
        run(2, 25);
        check(tmo_after_start == 0, "R9 timeout cleared by start", tmo_after_start, 0);
        check(forced_pulls == 0, "R5 no pull while SCL stretched", forced_pulls, 0);
        check(saw_done == 1 && pulses == 2, "R5 run completes after stretch", pulses, 2);
        check(elapsed > 25, "R5 run delayed by stretch", elapsed, 26);

        // R7: endless stretch gives up without pulsing
        run(2, -1);
        check(saw_tmo == 1 && saw_done == 0, "R7 timeout on long stretch", saw_tmo, 1);
        check(pulses == 0, "R7 no pulse issued", pulses, 0);
        check(elapsed >= SLIMIT, "R7 waited the stretch limit", elapsed, SLIMIT);
        check(!scl_oe && !sda_oe, "R7 lines released", {scl_oe, sda_oe}, 0);

        // R2: free bus straight after a timeout
        run(0, 0);
        check(saw_done == 1 && pulses == 0, "R2 free bus no pulses", pulses, 0);
        check(tmo == 0, "R9 timeout low after good run", tmo, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule